// File: doc/BRIEF.md
# External Interrupt Polarity Converter

This block is the front end for three external interrupt pins. Its downstream interrupt controller takes only active-high levels or rising edges. Each pin passes through a synchronizer and is then sampled, either on every clock or only on cycles marked by a slow-clock strobe. The sample is matched against one of four trigger conditions: high level, low level, rising edge or falling edge. Every line drives one normalized active-high request, so a low level or a falling edge looks to the controller like a high level or a rising edge.

Each line has an 8-bit control byte, and all three bytes share one 32-bit word. Software reads the whole word. A write carries one strobe per line, so it changes only the bytes it selects. An edge leaves a sticky pending flag, and software clears it by writing 1 to that bit. In level modes the pending bit shows the active level directly and needs no clearing. The enable bit gates the outgoing request.

Top module: `irq_polarity_front`

## Requirements
- R1: After reset the whole read word is 0 and every request output is low. Every line is then disabled, in level-high mode, with no pending flag.
- R2: Line 0's byte is in word bits 23:16, line 1's in 15:8 and line 2's in 7:0. Bits 31:24 read 0. Within a byte, bit 0 is pending, bit 4 selects fast sampling, bit 5 is enable and bits 7:6 are the trigger type; bits 3:1 read 0.
- R3: A write updates only the line bytes whose `wr_lane` bit is set (bit i selects line i). The other bytes keep their values.
- R4: Trigger type 00 is level high. With fast sampling, a change on the pin reaches the request three clock edges after the pin changes, and not earlier.
- R5: Trigger type 01 is level low. The request is the inverse of the pin, and the pending bit reads 1 while the pin is low.
- R6: Trigger type 10 is rising edge. A rising edge sets pending and raises the request. Both stay high after the pin falls, until software writes 1 to the pending bit.
- R7: Trigger type 11 is falling edge. A falling edge on the pin produces the same sticky pending and high request that a rising edge produces in type 10.
- R8: Writing 0 to the pending bit leaves a set edge pending flag unchanged.
- R9: While enable (bit 5) is 0 the request stays low. An edge seen while disabled is still recorded as pending and raises the request once the line is enabled.
- R10: With bit 4 at 0, the pin is sampled only on cycles where `slow_tick` is high. A pin change is not seen until such a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe marking slow-clock sample points |
| pin_in | input | 3 | Raw external interrupt pins, bit i is line i |
| wr_en | input | 1 | Register write request |
| wr_lane | input | 3 | Per-line byte select for a write, bit i is line i |
| wr_data | input | 32 | Write data in the packed word layout |
| rd_data | output | 32 | Packed control and pending word |
| irq_out | output | 3 | Normalized active-high requests, bit i is line i |

## Verification
The bench checks the three-edge pin latency, because a missing or extra synchronizer stage would move the request one cycle early or late. It checks that a write to one line leaves the neighbouring bytes alone, which catches a design that rewrites the whole word. It checks that edge pending survives both the pin returning and a write of 0, so that a design treating 0 as a clear, or letting pending follow the pin, is reported. It also checks that an edge seen while the line is masked appears once the line is enabled, and that in slow mode nothing moves until a strobe arrives. Both would be lost by a design that gates detection rather than the output, or that ignores the sampling select.

// File: rtl/irq_front_pkg.sv
// Package: shared field layout, trigger encoding and word packing for the
// external interrupt front end. Assumes exactly three lines of 8-bit bytes.
package irq_front_pkg;
    localparam int NUM_LINES = 3;
    localparam int FIELD_W   = 8;
    localparam int WORD_W    = 32;

    localparam int PEND_BIT  = 0;
    localparam int FAST_BIT  = 4;
    localparam int EN_BIT    = 5;
    localparam int TYPE_LO   = 6;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_t;

    // Lowest word bit of a line's byte: line 0 sits highest.
    function automatic int lane_lo(input int line);
        return (NUM_LINES - 1 - line) * FIELD_W;
    endfunction
endpackage

// File: rtl/irq_pin_sync.sv
// Multi-stage synchronizer, one chain per pin. Assumes asynchronous pins
// and STAGES >= 2. Output is the last stage of each chain.
module irq_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_raw,
    output logic [WIDTH-1:0] pin_sync
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_chain
        logic [STAGES-1:0] chain_q;

        // Shift the raw pin through the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], pin_raw[b]};
        end

        assign pin_sync[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/irq_line_ctl.sv
// One interrupt line: control byte, sample register, trigger detection,
// sticky edge pending and the masked request. Assumes pin_s is already
// synchronous. An edge sets pending even while disabled; set beats clear.
module irq_line_ctl
    import irq_front_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_s,
    input  logic               slow_tick,
    input  logic               wr_sel,
    input  logic [FIELD_W-1:0] wr_field,
    output logic [FIELD_W-1:0] field_rd,
    output logic               irq
);
    logic  fast_q, en_q, samp_q, edge_pend_q;
    trig_t trig_q;
    logic  sample_en, edge_hit, clear_req, level_act, pend_view;

    // Control bits: written only when this line is selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
            en_q   <= 1'b0;
            trig_q <= TRIG_HIGH;
        end else if (wr_sel) begin
            fast_q <= wr_field[FAST_BIT];
            en_q   <= wr_field[EN_BIT];
            trig_q <= trig_t'(wr_field[TYPE_LO +: 2]);
        end
    end

    assign sample_en = fast_q | slow_tick;

    // Sample register: takes the pin on each sampling cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         samp_q <= 1'b0;
        else if (sample_en) samp_q <= pin_s;
    end

    // Edge condition: new sample against the held one.
    always_comb begin
        unique case (trig_q)
            TRIG_RISE: edge_hit = sample_en & ~samp_q &  pin_s;
            TRIG_FALL: edge_hit = sample_en &  samp_q & ~pin_s;
            default:   edge_hit = 1'b0;
        endcase
    end

    assign clear_req = wr_sel & wr_field[PEND_BIT];

    // Sticky edge pending: set on edge, cleared by a 1 write, idle in level modes.
    always_ff @(posedge clk) begin
        if (!rst_n)          edge_pend_q <= 1'b0;
        else if (!trig_q[1]) edge_pend_q <= 1'b0;
        else if (edge_hit)   edge_pend_q <= 1'b1;
        else if (clear_req)  edge_pend_q <= 1'b0;
    end

    assign level_act = samp_q ^ (trig_q == TRIG_LOW);
    assign pend_view = trig_q[1] ? edge_pend_q : level_act;
    assign irq       = en_q & pend_view;

    // Read-back byte assembly.
    always_comb begin
        field_rd                     = '0;
        field_rd[PEND_BIT]           = pend_view;
        field_rd[FAST_BIT]           = fast_q;
        field_rd[EN_BIT]             = en_q;
        field_rd[TYPE_LO +: 2]       = trig_q;
    end
endmodule

// File: rtl/irq_polarity_front.sv
// Top: synchronizes three pins, runs one line controller per pin and packs
// their bytes into one word. Assumes a single-cycle write with per-line strobes.
module irq_polarity_front
    import irq_front_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slow_tick,
    input  logic [NUM_LINES-1:0] pin_in,
    input  logic                 wr_en,
    input  logic [NUM_LINES-1:0] wr_lane,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [WORD_W-1:0]    rd_data,
    output logic [NUM_LINES-1:0] irq_out
);
    logic [NUM_LINES-1:0] pin_s;
    logic [FIELD_W-1:0]   field_rd [NUM_LINES];

    irq_pin_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .pin_sync (pin_s)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam int LO = lane_lo(g);

        irq_line_ctl line_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_s     (pin_s[g]),
            .slow_tick (slow_tick),
            .wr_sel    (wr_en & wr_lane[g]),
            .wr_field  (wr_data[LO +: FIELD_W]),
            .field_rd  (field_rd[g]),
            .irq       (irq_out[g])
        );
    end

    // Pack line bytes into the shared word, unused bits zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            rd_data[lane_lo(i) +: FIELD_W] = field_rd[i];
        end
    end
endmodule

// File: rtl/irq_front_chk.sv
// Checker for irq_polarity_front: relates the packed word and requests over
// time. Bound to the top module below.
module irq_front_chk
    import irq_front_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [NUM_LINES-1:0] wr_lane,
    input logic [WORD_W-1:0]    rd_data,
    input logic [NUM_LINES-1:0] irq_out
);
    // R1: first cycle out of reset shows cleared word and quiet outputs.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_data == '0 && irq_out == '0));

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
        localparam int LO = lane_lo(g);

        assert_mask_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_data[LO + EN_BIT] |-> !irq_out[g]);

        assert_lane_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_lane[g]) |=>
                (rd_data[LO + FAST_BIT +: 4] == $past(rd_data[LO + FAST_BIT +: 4])));

        assert_edge_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[LO + TYPE_LO + 1] && rd_data[LO + PEND_BIT]
             && !(wr_en && wr_lane[g])) |=> rd_data[LO + PEND_BIT]);
    end
endmodule

bind irq_polarity_front irq_front_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_lane (wr_lane),
    .rd_data (rd_data),
    .irq_out (irq_out)
);

// File: tb/irq_polarity_front_tb_top.sv
// Directed bench: one task per scenario, inputs driven and outputs sampled
// on the falling clock edge.
module irq_polarity_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic [2:0]  pin_in = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_lane = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  irq_out;

    int n_vec = 0;
    int n_bad = 0;

    localparam logic [7:0] F_PEND = 8'h01, F_FAST = 8'h10, F_EN = 8'h20;
    localparam logic [7:0] T_HIGH = 8'h00, T_LOW = 8'h40, T_RISE = 8'h80, T_FALL = 8'hC0;

    always #4 clk = ~clk;

    irq_polarity_front dut_i (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .pin_in(pin_in),
        .wr_en(wr_en), .wr_lane(wr_lane), .wr_data(wr_data),
        .rd_data(rd_data), .irq_out(irq_out)
    );

    function automatic logic [7:0] byte_of(input int line);
        return rd_data[(2 - line) * 8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_line(input int line, input logic [7:0] fld);
        wr_en   = 1'b1;
        wr_lane = 3'b001 << line;
        wr_data = 32'(fld) << ((2 - line) * 8);
        cyc(1);
        wr_en   = 1'b0;
        wr_lane = '0;
        wr_data = '0;
    endtask

    task automatic t_reset;
        chk("R1 word", rd_data, 32'h0);
        chk("R1 irq", 32'(irq_out), 32'h0);
    endtask

    task automatic t_level_high;
        wr_line(2, F_EN | F_FAST | T_HIGH);
        chk("R2 lane2 position", rd_data, 32'h0000_0030);
        pin_in[2] = 1'b1;
        cyc(2);
        chk("R4 not before third edge", 32'(irq_out[2]), 32'h0);
        cyc(1);
        chk("R4 level high asserted", 32'(irq_out[2]), 32'h1);
        pin_in[2] = 1'b0;
        cyc(3);
        chk("R4 level high released", 32'(irq_out[2]), 32'h0);
    endtask

    task automatic t_level_low;
        wr_line(0, F_EN | F_FAST | T_LOW);
        cyc(1);
        chk("R5 low pin gives request", 32'(irq_out[0]), 32'h1);
        chk("R5 pending shows level", 32'(byte_of(0)), 32'h71);
        chk("R3 R2 neighbours kept", rd_data, 32'h0071_0030);
        pin_in[0] = 1'b1;
        cyc(3);
        chk("R5 high pin drops request", 32'(irq_out[0]), 32'h0);
        wr_line(0, 8'h00);
    endtask

    task automatic t_rise;
        wr_line(1, F_EN | F_FAST | T_RISE);
        pin_in[1] = 1'b1;
        cyc(3);
        chk("R6 rising edge request", 32'(irq_out[1]), 32'h1);
        pin_in[1] = 1'b0;
        cyc(5);
        chk("R6 sticky after pin falls", 32'(byte_of(1)), 32'hB1);
        wr_line(1, F_EN | F_FAST | T_RISE);
        chk("R8 zero write keeps pending", 32'(irq_out[1]), 32'h1);
        wr_line(1, F_EN | F_FAST | T_RISE | F_PEND);
        chk("R6 cleared by one", 32'(irq_out[1]), 32'h0);
    endtask

    task automatic t_fall;
        wr_line(2, 8'h00);
        pin_in[2] = 1'b1;
        cyc(4);
        wr_line(2, F_EN | F_FAST | T_FALL);
        cyc(2);
        chk("R7 no edge yet", 32'(irq_out[2]), 32'h0);
        pin_in[2] = 1'b0;
        cyc(3);
        chk("R7 falling edge request", 32'(irq_out[2]), 32'h1);
        wr_line(2, F_EN | F_FAST | T_FALL | F_PEND);
        chk("R7 cleared", 32'(irq_out[2]), 32'h0);
    endtask

    task automatic t_mask;
        pin_in[0] = 1'b0;
        wr_line(0, F_FAST | T_RISE);
        cyc(4);
        pin_in[0] = 1'b1;
        cyc(4);
        chk("R9 masked request low", 32'(irq_out[0]), 32'h0);
        chk("R9 pending recorded", 32'(byte_of(0)), 32'h91);
        wr_line(0, F_EN | F_FAST | T_RISE);
        chk("R9 unmask raises request", 32'(irq_out[0]), 32'h1);
    endtask

    task automatic t_slow;
        pin_in[2] = 1'b0;
        wr_line(2, F_EN | T_HIGH);
        pin_in[2] = 1'b1;
        cyc(6);
        chk("R10 no tick no sample", 32'(irq_out[2]), 32'h0);
        slow_tick = 1'b1;
        cyc(1);
        slow_tick = 1'b0;
        chk("R10 tick samples", 32'(irq_out[2]), 32'h1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_level_high();
        t_level_low();
        t_rise();
        t_fall();
        t_mask();
        t_slow();
        cyc(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule